// File: doc/BRIEF.md
# Hash/Cipher Stream Router

This block sits between a single host data port and two processing engines: a message digest engine and a block cipher engine. The host programs an operation with one control write. That write carries an operation code, a packet length in bytes and a leading offset in 32-bit words. After that, the host pushes 32-bit words through one fixed input port. The router decides, for each word as it is accepted, whether the word goes into the hash input queue, the cipher input queue, or both. Each queue holds 512 bits by default. In the cipher-then-hash chain, every word the cipher engine returns is queued for the host and is also pushed back into the hash input queue.

A word is accepted only when every queue it must enter has a free slot, so a word is never delivered to one path and lost on the other. A length of zero opens a packet of unknown size. That packet stays open until the next control write, which closes it and emits an end-of-packet pulse so that the engines can add their final padding. If a control write arrives while a packet of known size still lacks words, that packet is abandoned and an error flag is raised.

Top module: `hc_stream_router`

## Requirements
- R1: After reset no operation is active: `din_ready`, `hash_valid`, `ciph_valid`, `dout_valid`, `st_err` and `pkt_close` are 0, and `st_newop` is 1.
- R2: Operation codes on `ctl_op`: 0 idle, 1 hash only, 2 cipher only, 3 hash-then-cipher, 4 cipher-then-hash. Codes 5 to 7 act as idle, and idle accepts no words. In hash-only mode every accepted word enters the hash queue in arrival order.
- R3: In cipher-only mode every accepted word enters the cipher queue in arrival order, and none enters the hash queue.
- R4: In hash-then-cipher mode every accepted word enters the hash queue. Word number k of the packet, counted from 0, also enters the cipher queue when k >= offset.
- R5: In cipher-then-hash mode, words with k < offset enter only the hash queue and later words enter only the cipher queue. Every word the cipher engine returns enters both the output queue and the hash queue. A returned word takes the hash queue slot ahead of an input word in the same cycle.
- R6: With a nonzero length L, exactly ceil(L/4) words are accepted and `din_ready` then stays low. `st_newop` is 0 while such a packet lacks words and 1 otherwise.
- R7: With length 0, words are accepted with no limit until the next control write, and `st_newop` stays 1.
- R8: `pkt_close` is a one-cycle pulse. It follows the cycle that accepts the last word of a bounded packet, and it follows a control write that ends an active packet of unknown length.
- R9: `din_ready` is 0 whenever any queue the next word needs is full. No queue is written beyond its depth.
- R10: A control write made while a bounded packet still lacks words sets `st_err` to 1. Any other control write sets it to 0. It changes at no other time.
- R11: No input word is accepted in a cycle that carries a control write.
- R12: `cres_ready` is 0 when the output queue is full, or in cipher-then-hash mode when the hash queue is full. Returned words leave on `dout_data` in order and hold while `dout_ready` is 0.
- R13: `st_space` is 1 when a packet is open and every queue the next word needs has room. `st_avail` equals `dout_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_op | input | 3 | Operation code |
| ctl_len | input | FW | Packet length in bytes, 0 = unknown length |
| ctl_ofs | input | FW | Leading offset in 32-bit words |
| din_valid | input | 1 | Host word present |
| din_data | input | DW | Host word |
| din_ready | output | 1 | Host word accepted this cycle if valid |
| hash_valid | output | 1 | Hash queue has a word |
| hash_data | output | DW | Head of hash queue |
| hash_ready | input | 1 | Hash engine takes the head word |
| ciph_valid | output | 1 | Cipher queue has a word |
| ciph_data | output | DW | Head of cipher queue |
| ciph_ready | input | 1 | Cipher engine takes the head word |
| cres_valid | input | 1 | Cipher engine result present |
| cres_data | input | DW | Cipher engine result |
| cres_ready | output | 1 | Result taken this cycle if valid |
| dout_valid | output | 1 | Output queue has a word |
| dout_data | output | DW | Head of output queue |
| dout_ready | input | 1 | Host reads the head word |
| st_newop | output | 1 | A new operation may be written |
| st_space | output | 1 | Room for the next input word |
| st_avail | output | 1 | Output data ready to read |
| st_err | output | 1 | Last control write abandoned a packet |
| pkt_close | output | 1 | End-of-packet pulse to the engines |

## Verification
The bench builds the router with hash and cipher queues four words deep and an output queue two words deep. With these depths, full queues and the stalls they cause occur within a few cycles of random back-pressure. This makes reachable the all-or-nothing acceptance rule, the priority of returned cipher words over input words at the hash queue, and the result stall on a full output queue. Short byte lengths that are not multiples of four exercise the rounding of the word count, and small offsets move the split point inside every packet.

// File: rtl/hcr_pkg.sv
// Shared types for the hash/cipher stream router.
// Assumes: operation codes above the last defined value mean idle.
package hcr_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_HASH   = 3'd1,
        OP_CIPH   = 3'd2,
        OP_HTHENC = 3'd3,
        OP_CTHENH = 3'd4
    } hcr_op_e;

    typedef struct packed {
        logic to_hash;
        logic to_ciph;
    } hcr_route_t;

    // Map a raw code onto a defined operation.
    function automatic hcr_op_e hcr_decode(input logic [2:0] code);
        case (code)
            3'd1:    return OP_HASH;
            3'd2:    return OP_CIPH;
            3'd3:    return OP_HTHENC;
            3'd4:    return OP_CTHENH;
            default: return OP_IDLE;
        endcase
    endfunction

    // Destination queues of a word, given the operation and whether it lies before the offset.
    function automatic hcr_route_t hcr_route(input hcr_op_e op, input logic lead);
        hcr_route_t r;
        r = '0;
        case (op)
            OP_HASH:   r = '{to_hash: 1'b1,  to_ciph: 1'b0};
            OP_CIPH:   r = '{to_hash: 1'b0,  to_ciph: 1'b1};
            OP_HTHENC: r = '{to_hash: 1'b1,  to_ciph: !lead};
            OP_CTHENH: r = '{to_hash: lead,  to_ciph: !lead};
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hcr_fifo.sv
// Synchronous show-ahead word queue.
// Assumes: DEPTH >= 2; a push when full or a pop when empty is ignored.
module hcr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = mem[rd_ptr];

    // Store a pushed word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hcr_steer.sv
// Operation registers, per-packet word counter and routing decision.
// Assumes: accept is never high in a cycle with ctl_wr (the top enforces this).
module hcr_steer
    import hcr_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [2:0]    ctl_op,
    input  logic [FW-1:0] ctl_len,
    input  logic [FW-1:0] ctl_ofs,
    input  logic          accept,
    output logic          to_hash,
    output logic          to_ciph,
    output logic          fwd,
    output logic          pkt_open,
    output logic          busy,
    output logic          err,
    output logic          close_pls
);
    hcr_op_e       op_q;
    logic          unb_q;
    logic [FW-1:0] need_q, ofs_q, cnt_q;
    logic          active, done, lead, last_word;
    hcr_route_t    rt;

    assign active    = (op_q != OP_IDLE);
    assign done      = !unb_q && (cnt_q == need_q);
    assign pkt_open  = active && !done;
    assign busy      = active && !unb_q && !done;
    assign lead      = (cnt_q < ofs_q);
    assign rt        = hcr_route(op_q, lead);
    assign to_hash   = rt.to_hash;
    assign to_ciph   = rt.to_ciph;
    assign fwd       = (op_q == OP_CTHENH);
    assign last_word = !unb_q && (FW'(cnt_q + 1'b1) == need_q);

    // Load a new operation or count an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            unb_q  <= 1'b0;
            need_q <= '0;
            ofs_q  <= '0;
            cnt_q  <= '0;
            err    <= 1'b0;
        end else if (ctl_wr) begin
            op_q   <= hcr_decode(ctl_op);
            unb_q  <= (ctl_len == '0);
            need_q <= FW'(((FW + 1)'(ctl_len) + (FW + 1)'(3)) >> 2);
            ofs_q  <= ctl_ofs;
            cnt_q  <= '0;
            err    <= busy;
        end else if (accept && (cnt_q != '1)) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Flag the end of a packet for the engines' padding.
    always_ff @(posedge clk) begin
        if (!rst_n) close_pls <= 1'b0;
        else        close_pls <= (ctl_wr && active && unb_q) || (accept && last_word);
    end

endmodule

// File: rtl/hc_stream_router.sv
// Hash/cipher stream router: one host word port feeding a hash queue and a
// cipher queue, with cipher results queued for the host and optionally
// chained into the hash queue.
// Assumes: engines follow valid/ready; queue depths >= 2.
module hc_stream_router #(
    parameter int DW       = 32,
    parameter int FW       = 16,
    parameter int HQ_DEPTH = 16,
    parameter int CQ_DEPTH = 16,
    parameter int OQ_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [2:0]    ctl_op,
    input  logic [FW-1:0] ctl_len,
    input  logic [FW-1:0] ctl_ofs,
    input  logic          din_valid,
    input  logic [DW-1:0] din_data,
    output logic          din_ready,
    output logic          hash_valid,
    output logic [DW-1:0] hash_data,
    input  logic          hash_ready,
    output logic          ciph_valid,
    output logic [DW-1:0] ciph_data,
    input  logic          ciph_ready,
    input  logic          cres_valid,
    input  logic [DW-1:0] cres_data,
    output logic          cres_ready,
    output logic          dout_valid,
    output logic [DW-1:0] dout_data,
    input  logic          dout_ready,
    output logic          st_newop,
    output logic          st_space,
    output logic          st_avail,
    output logic          st_err,
    output logic          pkt_close
);
    logic          to_hash, to_ciph, fwd, pkt_open, busy;
    logic          hq_full, hq_empty, cq_full, cq_empty, oq_full, oq_empty;
    logic          fwd_push, room, accept, hq_push, cq_push, oq_push;
    logic [DW-1:0] hq_wdata;

    // Result path: output queue must have room, and the hash queue too when chaining.
    assign cres_ready = !oq_full && (!fwd || !hq_full);
    assign fwd_push   = fwd && cres_valid && cres_ready;
    assign oq_push    = cres_valid && cres_ready;

    // Input path: every needed queue must take the word, with chained results first.
    assign room      = (!to_hash || (!hq_full && !fwd_push)) && (!to_ciph || !cq_full);
    assign din_ready = pkt_open && !ctl_wr && room;
    assign accept    = din_valid && din_ready;

    assign hq_push  = (accept && to_hash) || fwd_push;
    assign hq_wdata = fwd_push ? cres_data : din_data;
    assign cq_push  = accept && to_ciph;

    assign hash_valid = !hq_empty;
    assign ciph_valid = !cq_empty;
    assign dout_valid = !oq_empty;
    assign st_newop   = !busy;
    assign st_space   = pkt_open && room;
    assign st_avail   = !oq_empty;

    hcr_steer #(.FW(FW)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_op   (ctl_op),
        .ctl_len  (ctl_len),
        .ctl_ofs  (ctl_ofs),
        .accept   (accept),
        .to_hash  (to_hash),
        .to_ciph  (to_ciph),
        .fwd      (fwd),
        .pkt_open (pkt_open),
        .busy     (busy),
        .err      (st_err),
        .close_pls(pkt_close)
    );

    hcr_fifo #(.W(DW), .DEPTH(HQ_DEPTH)) u_hq (
        .clk(clk), .rst_n(rst_n), .push(hq_push), .wdata(hq_wdata),
        .pop(hash_ready), .rdata(hash_data), .full(hq_full), .empty(hq_empty)
    );

    hcr_fifo #(.W(DW), .DEPTH(CQ_DEPTH)) u_cq (
        .clk(clk), .rst_n(rst_n), .push(cq_push), .wdata(din_data),
        .pop(ciph_ready), .rdata(ciph_data), .full(cq_full), .empty(cq_empty)
    );

    hcr_fifo #(.W(DW), .DEPTH(OQ_DEPTH)) u_oq (
        .clk(clk), .rst_n(rst_n), .push(oq_push), .wdata(cres_data),
        .pop(dout_ready), .rdata(dout_data), .full(oq_full), .empty(oq_empty)
    );

endmodule

// File: rtl/hcr_chk.sv
// Protocol checker for the stream router, attached with bind.
// Assumes: connected to the router's ports and its internal queue flags.
module hcr_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          din_valid,
    input logic          din_ready,
    input logic          st_err,
    input logic          dout_valid,
    input logic          dout_ready,
    input logic [DW-1:0] dout_data,
    input logic          hash_valid,
    input logic          hash_ready,
    input logic [DW-1:0] hash_data,
    input logic          cres_ready,
    input logic          oq_full,
    input logic          to_hash,
    input logic          hq_full,
    input logic          pkt_close
);
    p_ctl_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |-> !din_ready);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_wr) |-> $stable(st_err));

    p_full_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (to_hash && hq_full) |-> !din_ready);

    p_cres_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        oq_full |-> !cres_ready);

    p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    p_hash_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && !hash_ready) |=> (hash_valid && $stable(hash_data)));

    p_close_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_close |-> ($past(ctl_wr) || $past(din_valid && din_ready)));

endmodule

bind hc_stream_router hcr_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .st_err    (st_err),
    .dout_valid(dout_valid),
    .dout_ready(dout_ready),
    .dout_data (dout_data),
    .hash_valid(hash_valid),
    .hash_ready(hash_ready),
    .hash_data (hash_data),
    .cres_ready(cres_ready),
    .oq_full   (oq_full),
    .to_hash   (to_hash),
    .hq_full   (hq_full),
    .pkt_close (pkt_close)
);

// File: tb/hc_stream_router_test.sv
// Bench: behavioural queue model of the router compared on every clock.
module hc_stream_router_test;
    localparam int DW = 32, FW = 16, HQD = 4, CQD = 4, OQD = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic ctl_wr;
    logic [2:0] ctl_op;
    logic [FW-1:0] ctl_len, ctl_ofs;
    logic din_valid, din_ready, hash_valid, hash_ready, ciph_valid, ciph_ready;
    logic cres_valid, cres_ready, dout_valid, dout_ready;
    logic [DW-1:0] din_data, hash_data, ciph_data, cres_data, dout_data;
    logic st_newop, st_space, st_avail, st_err, pkt_close;

    hc_stream_router #(.DW(DW), .FW(FW), .HQ_DEPTH(HQD), .CQ_DEPTH(CQD), .OQ_DEPTH(OQD)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_op(ctl_op), .ctl_len(ctl_len),
        .ctl_ofs(ctl_ofs), .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
        .hash_valid(hash_valid), .hash_data(hash_data), .hash_ready(hash_ready),
        .ciph_valid(ciph_valid), .ciph_data(ciph_data), .ciph_ready(ciph_ready),
        .cres_valid(cres_valid), .cres_data(cres_data), .cres_ready(cres_ready),
        .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
        .st_newop(st_newop), .st_space(st_space), .st_avail(st_avail), .st_err(st_err),
        .pkt_close(pkt_close)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_op = 0, m_need = 0, m_ofs = 0, m_cnt = 0;
    bit m_unb = 0, m_err = 0, m_close = 0;
    logic [DW-1:0] mhq[$], mcq[$], moq[$], eng[$];
    string cur_req = "R2";
    int dut_acc = 0, dut_close_n = 0, mdl_close_n = 0;

    // stimulus knobs
    logic [31:0] rs = 32'h1234_abcd;
    int p_din = 80, p_hr = 70, p_cr = 70, p_dr = 70, p_cres = 70;
    bit cres_en = 0;

    task automatic roll(output int v);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        v = int'(rs % 100);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive result source, compare at the negedge, advance the model.
    task automatic step();
        bit act, done, open, lead, th, tc, fwd, hfull, cfull, ofull;
        bit e_cr, e_fwd, room, e_dr, accept, close_n, hp, cp, dp, take;
        @(negedge clk);
        cres_valid = (eng.size() > 0) && cres_en;
        cres_data  = (eng.size() > 0) ? eng[0] : '0;
        #1;
        act  = (m_op >= 1 && m_op <= 4);
        done = !m_unb && (m_cnt == m_need);
        open = act && !done;
        lead = (m_cnt < m_ofs);
        th = (m_op == 1) || (m_op == 3) || (m_op == 4 && lead);
        tc = (m_op == 2) || (m_op == 3 && !lead) || (m_op == 4 && !lead);
        fwd = (m_op == 4);
        hfull = (mhq.size() == HQD);
        cfull = (mcq.size() == CQD);
        ofull = (moq.size() == OQD);
        e_cr  = !ofull && (!fwd || !hfull);
        e_fwd = fwd && cres_valid && e_cr;
        room  = (!th || (!hfull && !e_fwd)) && (!tc || !cfull);
        e_dr  = open && !ctl_wr && room;

        chk(ctl_wr ? "R11" : "R9", "din_ready", 32'(din_ready), 32'(e_dr));
        chk("R12", "cres_ready", 32'(cres_ready), 32'(e_cr));
        chk(cur_req, "hash_valid", 32'(hash_valid), 32'(mhq.size() > 0));
        if (mhq.size() > 0) chk(cur_req, "hash_data", hash_data, mhq[0]);
        chk(cur_req, "ciph_valid", 32'(ciph_valid), 32'(mcq.size() > 0));
        if (mcq.size() > 0) chk(cur_req, "ciph_data", ciph_data, mcq[0]);
        chk("R12", "dout_valid", 32'(dout_valid), 32'(moq.size() > 0));
        if (moq.size() > 0) chk("R12", "dout_data", dout_data, moq[0]);
        chk("R6", "st_newop", 32'(st_newop), 32'(!(act && !m_unb && !done)));
        chk("R13", "st_space", 32'(st_space), 32'(open && room));
        chk("R13", "st_avail", 32'(st_avail), 32'(moq.size() > 0));
        chk("R10", "st_err", 32'(st_err), 32'(m_err));
        chk("R8", "pkt_close", 32'(pkt_close), 32'(m_close));

        if (din_valid && din_ready) dut_acc++;
        if (pkt_close) dut_close_n++;
        if (m_close) mdl_close_n++;

        accept  = din_valid && e_dr;
        close_n = (ctl_wr && act && m_unb) || (accept && !m_unb && (m_cnt + 1 == m_need));
        hp   = hash_ready && (mhq.size() > 0);
        cp   = ciph_ready && (mcq.size() > 0);
        dp   = dout_ready && (moq.size() > 0);
        take = cres_valid && e_cr;
        if (hp) void'(mhq.pop_front());
        if (cp) begin eng.push_back(mcq[0] ^ 32'h5A5A_0F0F); void'(mcq.pop_front()); end
        if (dp) void'(moq.pop_front());
        if (take) begin
            moq.push_back(cres_data);
            if (e_fwd) mhq.push_back(cres_data);
            void'(eng.pop_front());
        end
        if (accept && th) mhq.push_back(din_data);
        if (accept && tc) mcq.push_back(din_data);
        if (ctl_wr) begin
            m_err  = act && !m_unb && !done;
            m_op   = (ctl_op <= 3'd4) ? int'(ctl_op) : 0;
            m_unb  = (ctl_len == '0);
            m_need = (int'(ctl_len) + 3) / 4;
            m_ofs  = int'(ctl_ofs);
            m_cnt  = 0;
            dut_acc = 0;
        end else if (accept && m_cnt != 65535) begin
            m_cnt++;
        end
        m_close = close_n;
        @(posedge clk);
        #1;
    endtask

    task automatic randomize_drive();
        int r;
        roll(r); din_valid = (r < p_din);
        din_data = rs;
        roll(r); hash_ready = (r < p_hr);
        roll(r); ciph_ready = (r < p_cr);
        roll(r); dout_ready = (r < p_dr);
        roll(r); cres_en = (r < p_cres);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            ctl_wr = 1'b0;
            randomize_drive();
            step();
        end
    endtask

    task automatic ctl(input int op, input int len, input int ofs);
        randomize_drive();
        din_valid = 1'b1;
        ctl_wr  = 1'b1;
        ctl_op  = 3'(op);
        ctl_len = FW'(len);
        ctl_ofs = FW'(ofs);
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic drain(input int n);
        int sv;
        sv = p_din;
        p_din = 0; p_hr = 100; p_cr = 100; p_dr = 100; p_cres = 100;
        cyc(n);
        p_din = sv;
    endtask

    initial begin
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_op = '0; ctl_len = '0; ctl_ofs = '0;
        din_valid = 1'b0; din_data = '0; hash_ready = 1'b0; ciph_ready = 1'b0;
        dout_ready = 1'b0; cres_valid = 1'b0; cres_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "din_ready", 32'(din_ready), 0);
        chk("R1", "hash_valid", 32'(hash_valid), 0);
        chk("R1", "ciph_valid", 32'(ciph_valid), 0);
        chk("R1", "dout_valid", 32'(dout_valid), 0);
        chk("R1", "st_newop", 32'(st_newop), 1);
        chk("R1", "st_err", 32'(st_err), 0);
        chk("R1", "pkt_close", 32'(pkt_close), 0);
        @(posedge clk); #1;

        cur_req = "R2"; ctl(1, 20, 0); cyc(30); drain(10);
        cur_req = "R2"; ctl(6, 20, 0); cyc(10);
        chk("R2", "idle code accepts nothing", 32'(dut_acc), 0);
        cur_req = "R3"; ctl(2, 13, 0); cyc(30); drain(10);
        cur_req = "R4"; ctl(3, 40, 3); cyc(60); drain(12);
        cur_req = "R5"; ctl(4, 32, 2); cyc(60); drain(16);
        // R9: back-pressure on the hash engine fills its queue
        cur_req = "R9"; p_hr = 0; p_din = 100; ctl(3, 64, 1); cyc(20); p_hr = 70; cyc(60); drain(16);
        // R7: unknown length keeps accepting past any bound
        cur_req = "R7"; p_din = 100; p_hr = 100;
        ctl(1, 0, 0); cyc(90);
        chk("R7", "words accepted beyond 64", 32'(dut_acc > 64), 1);
        ctl(0, 0, 0); drain(10);
        // R10: abandon a long bounded packet, then a clean write
        cur_req = "R10"; p_din = 80;
        ctl(2, 400, 0); cyc(10); ctl(1, 8, 0);
        chk("R10", "error after abandon", 32'(st_err), 1);
        cyc(30); ctl(0, 0, 0);
        chk("R10", "error cleared", 32'(st_err), 0);
        drain(10);
        // mixed random packets
        cur_req = "R5";
        for (int k = 0; k < 60; k++) begin
            int r, op, len, ofs;
            roll(r); op = r % 8;
            roll(r); len = (r < 20) ? 0 : r;
            roll(r); ofs = r % 7;
            roll(p_din); roll(p_hr); roll(p_cr); roll(p_dr); roll(p_cres);
            ctl(op, len, ofs); cyc(50);
        end
        ctl(0, 0, 0); drain(30);
        chk("R8", "close pulse count", 32'(dut_close_n), 32'(mdl_close_n));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule